// File: doc/BRIEF.md
# Stack and Indexed Address Generator

This block produces the 16-bit byte addresses for every stack-relative and heap-relative memory access of a small accumulator machine. It holds three pointers: a stack pointer confined to a 4 kB window, a frame base pointer, and a heap base pointer. It drives a simple single-port memory request interface directly. The read path is combinational, so a read returns data in the same cycle as its request.

The sequencer takes one command at a time and stays busy until the command is done. Push writes at the stack pointer and then advances it. Pop steps the pointer back first and then reads. Frame-indexed and heap-indexed accesses add an unsigned 8-bit index to the matching base in two byte-wide steps. Subroutine entry fetches its own two-byte target from the instruction stream and saves the return address as two stack bytes. It then asks the fetch unit to jump. Subroutine exit pops the two bytes back and jumps to them. Neither sequence touches the frame base pointer; a separate command copies the stack pointer into it.

Top module: `stk_agu`

## Requirements
- R1: After reset the block is idle with no memory request, no read strobe and no jump strobe. The first push writes address 0x1000, the frame base is 0x1000 and the heap base is 0x2000.
- R2: Command code 0 (push) writes `cmd_data` at the current stack address and then advances the stack pointer by one. It takes 2 cycles counted from the accepting edge's cycle.
- R3: Command code 1 (pop) first steps the stack pointer back by one. In the next cycle it reads that address and returns the byte on `rd_data_o`. It takes 3 cycles.
- R4: The stack pointer wraps inside 0x1000..0x1FFF. A push at 0x1FFF is followed by a push to 0x1000, and a pop with the pointer at 0x1000 reads 0x1FFF.
- R5: Codes 2 (load) and 3 (store) access frame base plus `cmd_idx`, zero-extended. The low-byte carry propagates into the high byte, and each takes 4 cycles.
- R6: Codes 4 (load) and 5 (store) access heap base plus `cmd_idx`, zero-extended, with the sum wrapping modulo 2^16. Each takes 4 cycles.
- R7: Code 8 copies the current stack address into the frame base, and code 9 loads `cmd_val` into the heap base. Each takes 1 cycle and makes no memory access.
- R8: Code 6 (call) reads the target low byte at `cmd_val` and the high byte at `cmd_val`+1. It then pushes the return address `cmd_val`+2, low byte first, and pulses `pc_load_o` with the target. It takes 6 cycles and leaves the frame base unchanged.
- R9: Code 7 (return) pops the high byte and then the low byte, and pulses `pc_load_o` with the restored address. It takes 6 cycles and leaves the stack pointer where it was before the matching call.
- R10: A command offered while the block is busy is ignored. Codes 10 to 15 are ignored and leave the block idle, making no access.
- R11: Read results appear as a one-cycle `rd_valid_o` pulse in the cycle after the read, which is the first cycle with `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered; taken when `busy_o` is low |
| cmd_op | input | 4 | Command code |
| cmd_idx | input | 8 | Unsigned index for indexed accesses |
| cmd_data | input | 8 | Byte to write for push and indexed stores |
| cmd_val | input | 16 | Heap base value, or address of the call target bytes |
| busy_o | output | 1 | A command is in progress |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 16 | Access address |
| mem_wdata_o | output | 8 | Write byte |
| mem_rdata_i | input | 8 | Read byte, valid in the request cycle |
| rd_valid_o | output | 1 | `rd_data_o` holds a new read result |
| rd_data_o | output | 8 | Result of pop or indexed load |
| pc_load_o | output | 1 | Jump request |
| pc_value_o | output | 16 | Jump destination |

## Verification
A corrupted stack pointer appears at the very next push or pop as a wrong `mem_addr_o`, one cycle after the command is taken. A corrupted base pointer appears on the next indexed access, three cycles after that command is taken. A sequencer that skips or repeats a state changes the busy length. It also moves the `pc_load_o` pulse, or writes the return bytes in the wrong order, so a later return restores a wrong jump address. The bench therefore checks every command for address, direction, data and cycle count, and then issues a push after each call/return pair to confirm the pointer came back.

// File: rtl/stk_agu_pkg.sv
package stk_agu_pkg;

    typedef enum logic [3:0] {
        OP_PUSH  = 4'd0,
        OP_POP   = 4'd1,
        OP_LDS   = 4'd2,
        OP_STS   = 4'd3,
        OP_LDH   = 4'd4,
        OP_STH   = 4'd5,
        OP_CALL  = 4'd6,
        OP_RET   = 4'd7,
        OP_SETBP = 4'd8,
        OP_SETHP = 4'd9
    } op_e;

    typedef enum logic [4:0] {
        S_IDLE,
        S_PUSH,
        S_POP_DEC,
        S_POP_RD,
        S_IX_LO,
        S_IX_HI,
        S_IX_ACC,
        S_CALL_T0,
        S_CALL_T1,
        S_CALL_W0,
        S_CALL_W1,
        S_RET_D0,
        S_RET_R0,
        S_RET_D1,
        S_RET_R1,
        S_JMP
    } st_e;

endpackage

// File: rtl/stk_agu_addc.sv
module stk_agu_addc #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] sum,
    output logic         co
);
    logic [W:0] full;

    always_comb begin
        full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
        sum  = full[W-1:0];
        co   = full[W];
    end
endmodule

// File: rtl/stk_agu_spwrap.sv
module stk_agu_spwrap #(
    parameter int             AW   = 16,
    parameter int             OW   = 12,
    parameter logic [AW-1:0]  BASE = 16'h1000
) (
    input  logic [OW-1:0] off,
    output logic [AW-1:0] addr,
    output logic [OW-1:0] off_inc,
    output logic [OW-1:0] off_dec
);
    localparam logic [OW-1:0] ONE = OW'(1);

    always_comb begin
        addr    = BASE + AW'(off);
        off_inc = off + ONE;
        off_dec = off - ONE;
    end
endmodule

// File: rtl/stk_agu.sv
module stk_agu
    import stk_agu_pkg::*;
#(
    parameter int            DW         = 8,
    parameter int            AW         = 2 * DW,
    parameter int            STACK_OW   = 12,
    parameter logic [AW-1:0] STACK_BASE = 16'h1000,
    parameter logic [AW-1:0] HEAP_BASE  = 16'h2000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [3:0]    cmd_op,
    input  logic [DW-1:0] cmd_idx,
    input  logic [DW-1:0] cmd_data,
    input  logic [AW-1:0] cmd_val,
    output logic          busy_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          rd_valid_o,
    output logic [DW-1:0] rd_data_o,
    output logic          pc_load_o,
    output logic [AW-1:0] pc_value_o
);
    localparam logic [AW-1:0] PTR_STEP = AW'(1);

    typedef struct packed {
        st_e                 st;
        op_e                 op;
        logic [STACK_OW-1:0] sp;
        logic [AW-1:0]       bp;
        logic [AW-1:0]       hp;
        logic [AW-1:0]       ea;
        logic [AW-1:0]       ptr;
        logic [AW-1:0]       tgt;
        logic                cy;
        logic [DW-1:0]       idx;
        logic [DW-1:0]       wd;
        logic [DW-1:0]       rd;
        logic                rv;
    } agu_t;

    agu_t q, d;

    logic [AW-1:0]       sp_addr;
    logic [STACK_OW-1:0] sp_inc, sp_dec;
    logic [DW-1:0]       add_a, add_b, add_sum;
    logic                add_ci, add_co;
    logic [AW-1:0]       base;
    logic                is_store;

    stk_agu_spwrap #(
        .AW   (AW),
        .OW   (STACK_OW),
        .BASE (STACK_BASE)
    ) spw_i (
        .off     (q.sp),
        .addr    (sp_addr),
        .off_inc (sp_inc),
        .off_dec (sp_dec)
    );

    stk_agu_addc #(
        .W (DW)
    ) add_i (
        .a   (add_a),
        .b   (add_b),
        .ci  (add_ci),
        .sum (add_sum),
        .co  (add_co)
    );

    always_comb begin
        d           = q;
        d.rv        = 1'b0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = sp_addr;
        mem_wdata_o = q.wd;
        pc_load_o   = 1'b0;
        is_store    = (q.op == OP_STS) || (q.op == OP_STH);
        base        = ((q.op == OP_LDH) || (q.op == OP_STH)) ? q.hp : q.bp;
        add_a       = base[DW-1:0];
        add_b       = q.idx;
        add_ci      = 1'b0;

        unique case (q.st)
            S_IDLE: begin
                if (cmd_valid) begin
                    case (op_e'(cmd_op))
                        OP_PUSH: begin
                            d.st = S_PUSH;
                            d.wd = cmd_data;
                        end
                        OP_POP: d.st = S_POP_DEC;
                        OP_LDS, OP_STS, OP_LDH, OP_STH: begin
                            d.st  = S_IX_LO;
                            d.op  = op_e'(cmd_op);
                            d.idx = cmd_idx;
                            d.wd  = cmd_data;
                        end
                        OP_CALL: begin
                            d.st  = S_CALL_T0;
                            d.ptr = cmd_val;
                        end
                        OP_RET:   d.st = S_RET_D0;
                        OP_SETBP: d.bp = sp_addr;
                        OP_SETHP: d.hp = cmd_val;
                        default: ;
                    endcase
                end
            end
            S_PUSH: begin
                mem_req_o = 1'b1;
                mem_we_o  = 1'b1;
                d.sp      = sp_inc;
                d.st      = S_IDLE;
            end
            S_POP_DEC: begin
                d.sp = sp_dec;
                d.st = S_POP_RD;
            end
            S_POP_RD: begin
                mem_req_o = 1'b1;
                d.rd      = mem_rdata_i;
                d.rv      = 1'b1;
                d.st      = S_IDLE;
            end
            S_IX_LO: begin
                d.ea[DW-1:0] = add_sum;
                d.cy         = add_co;
                d.st         = S_IX_HI;
            end
            S_IX_HI: begin
                add_a         = base[AW-1:DW];
                add_b         = '0;
                add_ci        = q.cy;
                d.ea[AW-1:DW] = add_sum;
                d.st          = S_IX_ACC;
            end
            S_IX_ACC: begin
                mem_req_o  = 1'b1;
                mem_we_o   = is_store;
                mem_addr_o = q.ea;
                if (!is_store) begin
                    d.rd = mem_rdata_i;
                    d.rv = 1'b1;
                end
                d.st = S_IDLE;
            end
            S_CALL_T0: begin
                mem_req_o        = 1'b1;
                mem_addr_o       = q.ptr;
                d.tgt[DW-1:0]    = mem_rdata_i;
                d.ptr            = q.ptr + PTR_STEP;
                d.st             = S_CALL_T1;
            end
            S_CALL_T1: begin
                mem_req_o        = 1'b1;
                mem_addr_o       = q.ptr;
                d.tgt[AW-1:DW]   = mem_rdata_i;
                d.ptr            = q.ptr + PTR_STEP;
                d.st             = S_CALL_W0;
            end
            S_CALL_W0: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_wdata_o = q.ptr[DW-1:0];
                d.sp        = sp_inc;
                d.st        = S_CALL_W1;
            end
            S_CALL_W1: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_wdata_o = q.ptr[AW-1:DW];
                d.sp        = sp_inc;
                d.st        = S_JMP;
            end
            S_RET_D0: begin
                d.sp = sp_dec;
                d.st = S_RET_R0;
            end
            S_RET_R0: begin
                mem_req_o      = 1'b1;
                d.tgt[AW-1:DW] = mem_rdata_i;
                d.st           = S_RET_D1;
            end
            S_RET_D1: begin
                d.sp = sp_dec;
                d.st = S_RET_R1;
            end
            S_RET_R1: begin
                mem_req_o      = 1'b1;
                d.tgt[DW-1:0]  = mem_rdata_i;
                d.st           = S_JMP;
            end
            S_JMP: begin
                pc_load_o = 1'b1;
                d.st      = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
            q.op <= OP_PUSH;
            q.bp <= STACK_BASE;
            q.hp <= HEAP_BASE;
        end else begin
            q <= d;
        end
    end

    assign busy_o     = (q.st != S_IDLE);
    assign rd_valid_o = q.rv;
    assign rd_data_o  = q.rd;
    assign pc_value_o = q.tgt;

endmodule

// File: rtl/stk_agu_chk.sv
module stk_agu_chk #(
    parameter int            DW         = 8,
    parameter int            AW         = 16,
    parameter int            STACK_OW   = 12,
    parameter logic [AW-1:0] STACK_BASE = 16'h1000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [3:0]    cmd_op,
    input logic [DW-1:0] cmd_data,
    input logic          busy_o,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic [AW-1:0] mem_addr_o,
    input logic [DW-1:0] mem_wdata_o,
    input logic          rd_valid_o,
    input logic          pc_load_o
);
    logic take;
    assign take = cmd_valid && !busy_o;

    a_r2_push_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd_op == 4'd0) |=> (mem_req_o && mem_we_o && mem_wdata_o == $past(cmd_data)));

    a_r4_push_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd_op == 4'd0) |=> (mem_addr_o[AW-1:STACK_OW] == STACK_BASE[AW-1:STACK_OW]));

    a_r3_pop_step_first: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd_op == 4'd1) |=> (busy_o && !mem_req_o));

    a_r11_rd_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> (!busy_o && $past(mem_req_o && !mem_we_o)));

    a_r8_call_jump_time: assert property (@(posedge clk) disable iff (!rst_n)
        $past(take && cmd_op == 4'd6, 5) |-> pc_load_o);

    a_r9_ret_jump_time: assert property (@(posedge clk) disable iff (!rst_n)
        $past(take && cmd_op == 4'd7, 5) |-> pc_load_o);

    a_r10_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> busy_o);

    a_r10_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd_op >= 4'd10) |=> !busy_o);

endmodule

bind stk_agu stk_agu_chk #(
    .DW         (DW),
    .AW         (AW),
    .STACK_OW   (STACK_OW),
    .STACK_BASE (STACK_BASE)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_data    (cmd_data),
    .busy_o      (busy_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .rd_valid_o  (rd_valid_o),
    .pc_load_o   (pc_load_o)
);

// File: tb/stk_agu_tb_top.sv
`timescale 1ns/1ps
module stk_agu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [7:0]  cmd_idx = '0;
    logic [7:0]  cmd_data = '0;
    logic [15:0] cmd_val = '0;
    logic        busy_o, mem_req_o, mem_we_o, rd_valid_o, pc_load_o;
    logic [15:0] mem_addr_o, pc_value_o;
    logic [7:0]  mem_wdata_o, mem_rdata_i, rd_data_o;

    always #2.5 clk = ~clk;

    stk_agu dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_idx(cmd_idx), .cmd_data(cmd_data), .cmd_val(cmd_val),
        .busy_o(busy_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
        .pc_load_o(pc_load_o), .pc_value_o(pc_value_o)
    );

    // small write-back memory model: 16 most recent writes, default pattern elsewhere
    logic [15:0] m_addr [16];
    logic [7:0]  m_data [16];
    logic        m_ok   [16];
    int          m_wp = 0;

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_ok[i] = 1'b0; m_addr[i] = '0; m_data[i] = '0;
        end
    end

    function automatic logic [7:0] peek(input logic [15:0] a);
        logic [7:0] v;
        v = a[7:0] ^ a[15:8] ^ 8'h5A;
        for (int k = 0; k < 16; k++) begin
            int s;
            s = (m_wp + k) % 16;
            if (m_ok[s] && m_addr[s] == a) v = m_data[s];
        end
        return v;
    endfunction

    always_comb mem_rdata_i = peek(mem_addr_o);

    always @(posedge clk) begin
        if (mem_req_o && mem_we_o) begin
            m_addr[m_wp] <= mem_addr_o;
            m_data[m_wp] <= mem_wdata_o;
            m_ok[m_wp]   <= 1'b1;
            m_wp         <= (m_wp + 1) % 16;
        end
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    logic        g_acc, g_we, g_rv, g_pl;
    logic [15:0] g_addr, g_pc;
    logic [7:0]  g_wd, g_rd;
    int          g_cyc;

    // issue one command; optionally keep offering a heap-base load while busy
    task automatic run(input logic [3:0] op, input logic [7:0] idx, input logic [7:0] dat,
                       input logic [15:0] val, input logic spam);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx; cmd_data = dat; cmd_val = val;
        g_acc = 1'b0; g_we = 1'b0; g_addr = '0; g_wd = '0; g_pl = 1'b0; g_pc = '0;
        g_cyc = 1;
        @(negedge clk);
        if (spam) begin
            cmd_op = 4'd9; cmd_val = 16'h0000;
        end else begin
            cmd_valid = 1'b0;
        end
        while (busy_o) begin
            g_cyc++;
            if (mem_req_o && !g_acc) begin
                g_acc = 1'b1; g_we = mem_we_o; g_addr = mem_addr_o; g_wd = mem_wdata_o;
            end
            if (pc_load_o) begin
                g_pl = 1'b1; g_pc = pc_value_o;
            end
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        g_rv = rd_valid_o; g_rd = rd_data_o;
    endtask

    function automatic string tag(input logic [3:0] op);
        case (op)
            4'd0: return "R2";
            4'd1: return "R3";
            4'd2, 4'd3: return "R5";
            4'd4, 4'd5: return "R6";
            default: return "R7";
        endcase
    endfunction

    // {op, idx, data, val, access, write, addr, read byte, cycles}
    localparam int NV = 14;
    localparam logic [65:0] VEC [NV] = '{
        {4'h0, 8'h00, 8'h11, 16'h0000, 1'b1, 1'b1, 16'h1000, 8'h00, 4'd2},
        {4'h0, 8'h00, 8'h22, 16'h0000, 1'b1, 1'b1, 16'h1001, 8'h00, 4'd2},
        {4'h8, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'h00, 4'd1},
        {4'h3, 8'h05, 8'h33, 16'h0000, 1'b1, 1'b1, 16'h1007, 8'h00, 4'd4},
        {4'h2, 8'h05, 8'h00, 16'h0000, 1'b1, 1'b0, 16'h1007, 8'h33, 4'd4},
        {4'h1, 8'h00, 8'h00, 16'h0000, 1'b1, 1'b0, 16'h1001, 8'h22, 4'd3},
        {4'h4, 8'hFF, 8'h00, 16'h0000, 1'b1, 1'b0, 16'h20FF, 8'h85, 4'd4},
        {4'h9, 8'h00, 8'h00, 16'h30F8, 1'b0, 1'b0, 16'h0000, 8'h00, 4'd1},
        {4'h5, 8'h10, 8'h44, 16'h0000, 1'b1, 1'b1, 16'h3108, 8'h00, 4'd4},
        {4'h4, 8'h10, 8'h00, 16'h0000, 1'b1, 1'b0, 16'h3108, 8'h44, 4'd4},
        {4'h1, 8'h00, 8'h00, 16'h0000, 1'b1, 1'b0, 16'h1000, 8'h11, 4'd3},
        {4'h1, 8'h00, 8'h00, 16'h0000, 1'b1, 1'b0, 16'h1FFF, 8'hBA, 4'd3},  // R4 pop wrap
        {4'h0, 8'h00, 8'h55, 16'h0000, 1'b1, 1'b1, 16'h1FFF, 8'h00, 4'd2},  // R4
        {4'h0, 8'h00, 8'h66, 16'h0000, 1'b1, 1'b1, 16'h1000, 8'h00, 4'd2}   // R4 push wrap
    };

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "busy", busy_o, 0);
        chk("R1", "mem_req", mem_req_o, 0);
        chk("R1", "rd_valid", rd_valid_o, 0);
        chk("R1", "pc_load", pc_load_o, 0);

        for (int v = 0; v < NV; v++) begin
            logic [65:0] e;
            string t;
            e = VEC[v];
            t = (v >= 11) ? "R4" : tag(e[65:62]);
            if (v == 0) t = "R1";
            run(e[65:62], e[61:54], e[53:46], e[45:30], 1'b0);
            chk(t, "cycles", g_cyc, e[3:0]);
            chk(t, "access", g_acc, e[29]);
            if (e[29]) begin
                chk(t, "addr", g_addr, e[27:12]);
                chk(t, "write", g_we, e[28]);
                if (e[28]) chk(t, "wdata", g_wd, e[53:46]);
                else begin
                    chk("R11", "rd_valid", g_rv, 1);
                    chk(t, "rd_data", g_rd, e[11:4]);
                end
            end
        end
        // R11 strobe lasts one cycle
        @(negedge clk);
        chk("R11", "rd_valid drop", rd_valid_o, 0);

        // R8 call: target bytes from 0x01FE/0x01FF, return 0x0200 pushed at 0x1001/0x1002
        run(4'd6, 8'h00, 8'h00, 16'h01FE, 1'b0);
        chk("R8", "cycles", g_cyc, 6);
        chk("R8", "pc_load", g_pl, 1);
        chk("R8", "target", g_pc, 16'hA4A5);
        chk("R8", "ret lo", peek(16'h1001), 8'h00);
        chk("R8", "ret hi", peek(16'h1002), 8'h02);
        run(4'd2, 8'h00, 8'h00, 16'h0000, 1'b0);
        chk("R8", "frame base kept", g_addr, 16'h1002);

        // R9 return, with a heap-base load offered throughout (R10)
        run(4'd7, 8'h00, 8'h00, 16'h0000, 1'b1);
        chk("R9", "cycles", g_cyc, 6);
        chk("R9", "pc_load", g_pl, 1);
        chk("R9", "restored pc", g_pc, 16'h0200);
        chk("R9", "first pop addr", g_addr, 16'h1002);
        run(4'd4, 8'h00, 8'h00, 16'h0000, 1'b0);
        chk("R10", "heap base kept", g_addr, 16'h30F8);
        run(4'd0, 8'h00, 8'h77, 16'h0000, 1'b0);
        chk("R9", "sp restored", g_addr, 16'h1001);

        // R10 reserved code
        run(4'hC, 8'h00, 8'h00, 16'h0000, 1'b0);
        chk("R10", "reserved cycles", g_cyc, 1);
        chk("R10", "reserved access", g_acc, 0);
        run(4'd1, 8'h00, 8'h00, 16'h0000, 1'b0);
        chk("R10", "sp after reserved", g_addr, 16'h1001);
        chk("R10", "pop data", g_rd, 8'h77);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule